// File: doc/BRIEF.md
# Chained Unsigned Multiply-Accumulate Unit

This block multiplies two unsigned operands A and B to a full double-width product and adds a third unsigned operand C to it. C is zero-extended before the addition. The sum always fits in twice the operand width. Its lower half is returned as the primary result. Its upper half is returned as a secondary result. Software writes that upper half back over the register that held C.

This arrangement supports chaining. A scalar is multiplied by each limb of a big-integer vector in turn, and each operation's upper half becomes the C of the next operation. That upper half therefore acts as a rolling carry. After the last limb, the carry holds the most significant limb of the product.

A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. The multiplier is iterative and consumes DIGIT_W bits of A per cycle. A controller steps through three named states:

- IDLE is the state where the unit is ready. An accepted request loads the operands and moves the controller to CALC.
- CALC runs one shift-and-add step per cycle. After OP_W/DIGIT_W steps, the last-step transition leads to COMMIT.
- COMMIT latches both result halves and raises a one-cycle done pulse. It always returns to IDLE.

Top module: `wmc_unit`

## Requirements
- R1: `res_lo` equals (A*B + C) mod 2^OP_W, where A, B and C are all treated as unsigned, and the product is formed at the full 2*OP_W width before C is added.
- R2: `res_hi` equals bits 2*OP_W-1 down to OP_W of A*B + C. No overflow indication exists, because the sum always fits in 2*OP_W bits.
- R3: C is zero-extended, never sign-extended or shifted. With A=0, B=0 and C having its top bit set, the results are `res_hi`=0 and `res_lo`=C.
- R4: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. While a computation is in progress, `req_valid` and the operand ports are ignored, and the response reflects the operands of the accepted request.
- R5: `rsp_done` is high for exactly one cycle. It is sampled high after the (OP_W/DIGIT_W + 1)-th rising edge that follows the accepting edge; for the defaults, that is 9 edges later.
- R6: `res_lo` and `res_hi` change only together with a `rsp_done` pulse. They stay stable between pulses, including while the next computation runs.
- R7: After reset, `req_ready`=1, `rsp_done`=0, `res_lo`=0 and `res_hi`=0.
- R8: With A=B=C=2^64-1, the results are `res_lo`=0 and `res_hi`=2^64-1.
- R9: Feeding each `res_hi` back as the next C, with the scalar as B and successive limbs as A, yields the limbs of the scalar-by-vector product; the final `res_hi` is the top limb.
- R10: `req_ready` is low from the edge after acceptance until the cycle in which `rsp_done` is high, and it is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| op_a | input | OP_W | Multiplicand A |
| op_b | input | OP_W | Multiplier B |
| op_c | input | OP_W | Addend / carry-in C |
| rsp_done | output | 1 | One-cycle pulse: new results present |
| res_lo | output | OP_W | Low half of A*B+C |
| res_hi | output | OP_W | High half of A*B+C (carry-out) |

## Verification
Both results and the done pulse are due together, 9 rising edges after the accepting edge for the default 64-bit operands with 8-bit digits. `req_ready` is due to fall one edge after acceptance. Each operation task drives inputs on falling edges and counts rising edges from the accepting edge. It checks the results only at the falling edge where `rsp_done` is first seen, and it compares the edge count with the required latency. During the busy cycles, the same task checks that `req_ready` stays low and that the previous results stay unchanged.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

    typedef enum logic [1:0] {
        WMC_IDLE   = 2'd0,
        WMC_CALC   = 2'd1,
        WMC_COMMIT = 2'd2
    } wmc_state_e;

endpackage

// File: rtl/wmc_ctrl.sv
module wmc_ctrl
    import wmc_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    output logic req_ready_o,
    output logic load_o,
    output logic step_o,
    output logic commit_o
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    wmc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WMC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WMC_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == WMC_CALC) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // transitions: accept, last step, commit done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WMC_IDLE:   if (req_valid_i) state_d = WMC_CALC;
            WMC_CALC:   if (cnt_q == LAST_STEP) state_d = WMC_COMMIT;
            WMC_COMMIT: state_d = WMC_IDLE;
            default:    state_d = WMC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready_o = 1'b0;
        load_o      = 1'b0;
        step_o      = 1'b0;
        commit_o    = 1'b0;
        unique case (state_q)
            WMC_IDLE: begin
                req_ready_o = 1'b1;
                load_o      = req_valid_i;
            end
            WMC_CALC:   step_o   = 1'b1;
            WMC_COMMIT: commit_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wmc_digit_mul.sv
module wmc_digit_mul #(
    parameter int DIGIT_W = 8,
    parameter int ACC_W   = 128
) (
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic [ACC_W-1:0]   mcand_i,
    output logic [ACC_W-1:0]   pp_o
);

    generate
        if (DIGIT_W == 1) begin : g_bit
            // radix-2: a partial product is a gated copy
            assign pp_o = digit_i[0] ? mcand_i : '0;
        end else begin : g_digit
            assign pp_o = ACC_W'(digit_i) * mcand_i;
        end
    endgenerate

endmodule

// File: rtl/wmc_datapath.sv
module wmc_datapath #(
    parameter int OP_W    = 64,
    parameter int DIGIT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            commit_i,
    input  logic [OP_W-1:0] op_a_i,
    input  logic [OP_W-1:0] op_b_i,
    input  logic [OP_W-1:0] op_c_i,
    output logic            done_o,
    output logic [OP_W-1:0] res_lo_o,
    output logic [OP_W-1:0] res_hi_o
);

    localparam int ACC_W = 2 * OP_W;

    logic [OP_W-1:0]  a_q;
    logic [ACC_W-1:0] b_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] pp;

    wmc_digit_mul #(
        .DIGIT_W(DIGIT_W),
        .ACC_W  (ACC_W)
    ) mul_i (
        .digit_i(a_q[DIGIT_W-1:0]),
        .mcand_i(b_q),
        .pp_o   (pp)
    );

    // shift-and-add: acc starts at zero-extended C, gains digit*B each step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else if (load_i) begin
            a_q   <= op_a_i;
            b_q   <= ACC_W'(op_b_i);
            acc_q <= ACC_W'(op_c_i);
        end else if (step_i) begin
            a_q   <= a_q >> DIGIT_W;
            b_q   <= b_q << DIGIT_W;
            acc_q <= acc_q + pp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo_o <= '0;
            res_hi_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= commit_i;
            if (commit_i) begin
                res_lo_o <= acc_q[OP_W-1:0];
                res_hi_o <= acc_q[ACC_W-1:OP_W];
            end
        end
    end

endmodule

// File: rtl/wmc_unit.sv
module wmc_unit #(
    parameter int OP_W    = 64,
    parameter int DIGIT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic [OP_W-1:0] op_c,
    output logic            rsp_done,
    output logic [OP_W-1:0] res_lo,
    output logic [OP_W-1:0] res_hi
);

    localparam int STEPS = OP_W / DIGIT_W;

    logic load, step, commit;

    wmc_ctrl #(
        .STEPS(STEPS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid),
        .req_ready_o(req_ready),
        .load_o     (load),
        .step_o     (step),
        .commit_o   (commit)
    );

    wmc_datapath #(
        .OP_W   (OP_W),
        .DIGIT_W(DIGIT_W)
    ) dp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .commit_i(commit),
        .op_a_i  (op_a),
        .op_b_i  (op_b),
        .op_c_i  (op_c),
        .done_o  (rsp_done),
        .res_lo_o(res_lo),
        .res_hi_o(res_hi)
    );

endmodule

// File: rtl/wmc_unit_chk.sv
module wmc_unit_chk #(
    parameter int OP_W    = 64,
    parameter int DIGIT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [OP_W-1:0] op_a,
    input logic [OP_W-1:0] op_b,
    input logic [OP_W-1:0] op_c,
    input logic            rsp_done,
    input logic [OP_W-1:0] res_lo,
    input logic [OP_W-1:0] res_hi
);

    localparam int ACC_W   = 2 * OP_W;
    localparam int LATENCY = OP_W / DIGIT_W + 1;

    logic             busy_q;
    logic [15:0]      cnt_q;
    logic [ACC_W-1:0] ref_q;
    logic             accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            ref_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            ref_q  <= ACC_W'(op_a) * ACC_W'(op_b) + ACC_W'(op_c);
        end else if (rsp_done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> res_lo == ref_q[OP_W-1:0]);

    assert_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> res_hi == ref_q[ACC_W-1:OP_W]);

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (busy_q && cnt_q == 16'(LATENCY)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> ($stable(res_lo) && $stable(res_hi)));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

endmodule

bind wmc_unit wmc_unit_chk #(
    .OP_W   (OP_W),
    .DIGIT_W(DIGIT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_c     (op_c),
    .rsp_done (rsp_done),
    .res_lo   (res_lo),
    .res_hi   (res_hi)
);

// File: tb/wmc_unit_tb_top.sv
module wmc_unit_tb_top;

    localparam int OP_W    = 64;
    localparam int DIGIT_W = 8;
    localparam int LAT     = OP_W / DIGIT_W + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [OP_W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic            rsp_done;
    logic [OP_W-1:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wmc_unit #(.OP_W(OP_W), .DIGIT_W(DIGIT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .rsp_done(rsp_done),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one operation; optionally disturbs the inputs while busy (R4)
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                          input bit disturb, output logic [63:0] lo, output logic [63:0] hi);
        logic [63:0] prev_lo, prev_hi;
        int got;
        bit bad_ready, bad_hold;
        got = 0; bad_ready = 0; bad_hold = 0;
        @(negedge clk);
        prev_lo = res_lo; prev_hi = res_hi;
        chk("R4 ready before request", {127'd0, req_ready}, 128'd1);
        req_valid = 1'b1; op_a = a; op_b = b; op_c = c;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (disturb && k == 2) begin
                req_valid = 1'b1; op_a = ~a; op_b = ~b; op_c = ~c;
            end
            if (disturb && k == 6) req_valid = 1'b0;
            if (rsp_done) begin
                got = k;
                break;
            end
            if (req_ready) bad_ready = 1;
            if (res_lo !== prev_lo || res_hi !== prev_hi) bad_hold = 1;
        end
        req_valid = 1'b0;
        chk("R5 done latency", 128'(got), 128'(LAT));
        chk("R10 ready low while busy", {127'd0, bad_ready}, 128'd0);
        chk("R10 ready with done", {127'd0, req_ready}, 128'd1);
        chk("R6 results held while busy", {127'd0, bad_hold}, 128'd0);
        lo = res_lo; hi = res_hi;
        @(negedge clk);
        chk("R5 done is one cycle", {127'd0, rsp_done}, 128'd0);
    endtask

    task automatic test_op(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] c, input bit disturb);
        logic [63:0] lo, hi;
        logic [127:0] e;
        e = {64'd0, a} * {64'd0, b} + {64'd0, c};
        run_op(a, b, c, disturb, lo, hi);
        chk({req, " R1 low half"}, {64'd0, lo}, {64'd0, e[63:0]});
        chk({req, " R2 high half"}, {64'd0, hi}, {64'd0, e[127:64]});
    endtask

    task automatic test_reset();
        chk("R7 ready after reset", {127'd0, req_ready}, 128'd1);
        chk("R7 done after reset", {127'd0, rsp_done}, 128'd0);
        chk("R7 results after reset", {res_hi, res_lo}, 128'd0);
    endtask

    task automatic test_zero_ext();
        logic [63:0] lo, hi;
        run_op(64'd0, 64'd0, 64'h8000_0000_0000_0001, 0, lo, hi);
        chk("R3 zero-extended C high", {64'd0, hi}, 128'd0);
        chk("R3 zero-extended C low", {64'd0, lo}, 128'h8000_0000_0000_0001);
    endtask

    task automatic test_max();
        logic [63:0] lo, hi;
        run_op('1, '1, '1, 0, lo, hi);
        chk("R8 max low", {64'd0, lo}, 128'd0);
        chk("R8 max high", {64'd0, hi}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    task automatic test_hold_idle();
        logic [63:0] lo0, hi0;
        lo0 = res_lo; hi0 = res_hi;
        op_a = 64'h1234; op_b = 64'h5678; op_c = 64'h9;
        repeat (5) @(negedge clk);
        chk("R6 results held in idle", {res_hi, res_lo}, {hi0, lo0});
    endtask

    task automatic test_chain();
        logic [63:0] v [3];
        logic [63:0] s, carry, lo, hi;
        logic [255:0] full, got;
        v[0] = 64'hFFFF_FFFF_0000_0001; v[1] = 64'h0123_4567_89AB_CDEF; v[2] = 64'hDEAD_BEEF_CAFE_F00D;
        s = 64'hFEDC_BA98_7654_3211;
        full = {64'd0, v[2], v[1], v[0]} * {192'd0, s};
        carry = 64'd0;
        got = '0;
        for (int i = 0; i < 3; i++) begin
            run_op(v[i], s, carry, 0, lo, hi);
            got[i*64 +: 64] = lo;
            carry = hi;
        end
        got[255:192] = carry;
        chk("R9 chain limbs 0-1", got[127:0], full[127:0]);
        chk("R9 chain limbs 2-3", got[255:128], full[255:128]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_op("basic", 64'd3, 64'd5, 64'd7, 0);
        test_op("mixed", 64'hDEAD_BEEF_0000_1111, 64'h0F0F_F0F0_1234_5678, 64'hFFFF_0000_FFFF_0000, 0);
        test_op("single bits", 64'h8000_0000_0000_0000, 64'h2, 64'h1, 0);
        test_op("R4 disturbed while busy", 64'h1357_9BDF_2468_ACE0, 64'hAAAA_5555_AAAA_5555, 64'h42, 1);
        test_hold_idle();
        test_zero_ext();
        test_max();
        test_chain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule